// File: doc/BRIEF.md
# Multiframe Alignment Tracker with Q-Channel Insertion

This block sits on the terminal side of a basic-rate S/T line, behind the framer. For every received frame the framer gives a one-cycle strobe together with that frame's FA, N, M and S bit values. The block finds the 20-frame multiframe from those bits and tracks it. It then decides what goes into the FA bit of the upstream frame that answers each received frame.

While the block is hunting, or while multiframing is switched off, the upstream FA bit copies the downstream one. Alignment is declared after two clean multiframes in a row and dropped after two faulty ones in a row. Once aligned, the block carries a 4-bit Q codeword upstream, one bit every fifth frame. It gathers the per-frame S bits into a word that a microcontroller reads once per multiframe. Two interrupt pulses prompt that access: one marks every aligned multiframe, and the other marks a change in the received S word.

Top module: `mfsync_term`

## Requirements
- R1: After a synchronous reset, mf_sync, tx_fa, irq_mf and irq_sc are 0 and s_data is all zeros.
- R2: When mf_en is 0 or mf_sync is 0, tx_fa takes the rx_fa value of each strobed frame. It is valid from the clock edge that samples the strobe.
- R3: The expected pattern, with frames numbered 1..20 from the frame carrying M=1, is as follows. M is 1 in frame 1 only. FA=1 and N=0 in frames 1, 6, 11 and 16. FA=0 and N=1 in every other frame. mf_sync rises at the strobe of frame 20 of the second consecutive complete multiframe that matches this pattern.
- R4: While aligned, a multiframe with a pattern error does not drop mf_sync. One clean multiframe clears that error history. mf_sync falls at frame 20 of the second consecutive faulty multiframe.
- R5: While aligned, tx_fa carries q_data bits 3, 2, 1 and 0 in frames 1, 6, 11 and 16 respectively, and is 0 in all other frames.
- R6: q_data is sampled at frame 1. A change during a multiframe takes effect from the next multiframe.
- R7: The rx_s value of frame k (1..20) lands in s_data bit k-1. s_data changes only at frame 20 of a multiframe that ends aligned.
- R8: irq_mf is a one-cycle pulse after the frame-20 strobe of every multiframe that ends aligned, including the one that declares alignment.
- R9: irq_sc pulses together with irq_mf only when the newly copied s_data differs from the previous value.
- R10: mf_en=0 forces mf_sync to 0 on the next clock and clears all acquisition and loss history. The strobes then have no effect on alignment. After mf_en returns to 1, two fresh clean multiframes are needed.
- R11: While not aligned, an M=1 in an unexpected frame restarts frame numbering at that frame and discards the clean-multiframe count gathered so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| rx_fa | input | 1 | Received FA bit of the strobed frame |
| rx_n | input | 1 | Received N bit of the strobed frame |
| rx_m | input | 1 | Received M bit of the strobed frame |
| rx_s | input | 1 | Received S bit of the strobed frame |
| mf_en | input | 1 | Multiframing enable |
| q_data | input | 4 | Q codeword to send upstream |
| tx_fa | output | 1 | FA bit for the answering upstream frame |
| mf_sync | output | 1 | Multiframe alignment status |
| s_data | output | 20 | S bits of the last aligned multiframe |
| irq_mf | output | 1 | Per-multiframe interrupt pulse |
| irq_sc | output | 1 | S-word change interrupt pulse |

## Verification
The hardest situations to reach from the ports are a stray M bit that arrives partway through an acquisition, and loss hysteresis in which a clean multiframe sits between two faulty ones. Both depend on history that no port shows until a whole multiframe later. The bench drives a table of whole multiframes, each marked clean or carrying a flipped FA bit in frame 8, and checks mf_sync and the interrupt count after each one. It then cuts one multiframe short after seven frames, so that the next M bit lands out of place. This shows that a count of one clean multiframe is discarded.

// File: rtl/mfsync_pkg.sv
package mfsync_pkg;
  localparam int MF_FRAMES_DEF = 20;
  localparam int Q_STRIDE_DEF  = 5;

  typedef enum logic {
    MF_HUNT = 1'b0,
    MF_LOCK = 1'b1
  } mf_state_e;

  function automatic int q_width(input int frames, input int stride);
    return frames / stride;
  endfunction
endpackage

// File: rtl/mfs_phase.sv
module mfs_phase #(
  parameter  int FRAMES = 20,
  parameter  int STRIDE = 5,
  localparam int POS_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic             hunting,
  input  logic             rx_fa,
  input  logic             rx_n,
  input  logic             rx_m,
  output logic [POS_W-1:0] pos_now,
  output logic             pos_zero,
  output logic             q_slot,
  output logic             pat_err,
  output logic             realign,
  output logic             at_start,
  output logic             mf_last,
  output logic             phased
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAMES - 1);

  logic [POS_W-1:0] pos_reg;
  logic [POS_W-1:0] pos_inc;
  logic             grab;

  assign pos_inc = (pos_reg == LAST) ? '0 : pos_reg + 1'b1;
  // an M bit seen while hunting pins the frame count
  assign grab    = hunting && rx_m;
  assign pos_now = grab ? '0 : (phased ? pos_inc : '0);
  assign pos_zero = (pos_now == '0);
  assign q_slot  = ((pos_now % POS_W'(STRIDE)) == '0);
  assign pat_err = (rx_m != pos_zero) || (rx_fa != q_slot) || (rx_n == q_slot);
  assign realign = grab && phased && (pos_inc != '0);
  assign at_start = pos_zero && (phased || grab);
  assign mf_last = phased && (pos_now == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos_reg <= '0;
      phased  <= 1'b0;
    end else if (stb) begin
      pos_reg <= pos_now;
      if (grab) phased <= 1'b1;
    end
  end

  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos_reg <= LAST);

  // R11
  realign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && en && realign) |=> (pos_reg == '0));

  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb && en) |=> $stable(pos_reg));
endmodule

// File: rtl/mfs_sync_fsm.sv
module mfs_sync_fsm
  import mfsync_pkg::*;
#(
  parameter  int ACQ_MF  = 2,
  parameter  int LOSS_MF = 2,
  localparam int GW      = $clog2(ACQ_MF + 1),
  localparam int BW      = $clog2(LOSS_MF + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stb,
  input  logic pat_err,
  input  logic realign,
  input  logic at_start,
  input  logic mf_last,
  output logic hunting,
  output logic locked,
  output logic lock_nxt
);
  mf_state_e       st, st_n;
  logic [GW-1:0]   good, good_n;
  logic [BW-1:0]   bad, bad_n;
  logic            mf_bad, mf_bad_n;
  logic            bad_now;

  assign bad_now = mf_bad | pat_err;

  always_comb begin
    st_n     = st;
    good_n   = good;
    bad_n    = bad;
    mf_bad_n = mf_bad;
    if (stb) begin
      if (at_start) begin
        mf_bad_n = pat_err;
        if (realign) good_n = '0;
      end else if (mf_last) begin
        mf_bad_n = 1'b0;
        if (st == MF_HUNT) begin
          if (bad_now) begin
            good_n = '0;
          end else if (good == GW'(ACQ_MF - 1)) begin
            st_n   = MF_LOCK;
            good_n = '0;
            bad_n  = '0;
          end else begin
            good_n = good + 1'b1;
          end
        end else begin
          if (!bad_now) begin
            bad_n = '0;
          end else if (bad == BW'(LOSS_MF - 1)) begin
            st_n   = MF_HUNT;
            bad_n  = '0;
            good_n = '0;
          end else begin
            bad_n = bad + 1'b1;
          end
        end
      end else begin
        mf_bad_n = bad_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st     <= MF_HUNT;
      good   <= '0;
      bad    <= '0;
      mf_bad <= 1'b0;
    end else begin
      st     <= st_n;
      good   <= good_n;
      bad    <= bad_n;
      mf_bad <= mf_bad_n;
    end
  end

  assign hunting  = (st == MF_HUNT);
  assign locked   = (st == MF_LOCK);
  assign lock_nxt = en && (st_n == MF_LOCK);

  // R3
  lock_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(stb && mf_last && en));

  // R4
  loss_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(!en || (stb && mf_last)));

  // R10
  disable_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !locked);

  good_bound_chk: assert property (@(posedge clk) disable iff (rst)
    good < GW'(ACQ_MF));
endmodule

// File: rtl/mfs_qtx.sv
module mfs_qtx #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          locked,
  input  logic          stb,
  input  logic          pos_zero,
  input  logic          q_slot,
  input  logic          rx_fa,
  input  logic [QW-1:0] q_in,
  output logic          tx_fa
);
  logic [QW-1:0] q_shift;
  logic          sending;

  assign sending = en && locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_fa   <= 1'b0;
      q_shift <= '0;
    end else if (stb) begin
      if (sending) begin
        if (pos_zero) begin
          // R6: codeword captured once, at frame 1
          tx_fa   <= q_in[QW-1];
          q_shift <= q_in << 1;
        end else if (q_slot) begin
          tx_fa   <= q_shift[QW-1];
          q_shift <= q_shift << 1;
        end else begin
          tx_fa <= 1'b0;
        end
      end else begin
        tx_fa <= rx_fa;
      end
    end
  end

  // R2
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && !sending) |=> (tx_fa == $past(rx_fa)));

  // R5
  idle_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && sending && !q_slot) |=> !tx_fa);

  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(tx_fa));
endmodule

// File: rtl/mfs_schan.sv
module mfs_schan #(
  parameter  int FRAMES = 20,
  localparam int POS_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              commit,
  input  logic [POS_W-1:0]  pos_now,
  input  logic              rx_s,
  output logic [FRAMES-1:0] s_data,
  output logic              irq_mf,
  output logic              irq_sc
);
  logic [FRAMES-1:0] s_shadow;
  logic [FRAMES-1:0] s_next;

  always_comb begin
    s_next          = s_shadow;
    s_next[pos_now] = rx_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_shadow <= '0;
      s_data   <= '0;
      irq_mf   <= 1'b0;
      irq_sc   <= 1'b0;
    end else begin
      irq_mf <= 1'b0;
      irq_sc <= 1'b0;
      if (stb) begin
        s_shadow <= s_next;
        if (commit) begin
          s_data <= s_next;
          irq_mf <= 1'b1;
          irq_sc <= (s_next != s_data);
        end
      end
    end
  end

  // R7
  s_only_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (s_data != $past(s_data)) |-> irq_mf);

  // R8
  mf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mf |=> !irq_mf);

  // R9
  sc_with_mf_chk: assert property (@(posedge clk) disable iff (rst)
    irq_sc |-> irq_mf);
endmodule

// File: rtl/mfsync_term.sv
module mfsync_term
  import mfsync_pkg::*;
#(
  parameter  int FRAMES_PER_MF = MF_FRAMES_DEF,
  parameter  int Q_STRIDE      = Q_STRIDE_DEF,
  parameter  int ACQ_MF        = 2,
  parameter  int LOSS_MF       = 2,
  localparam int QW            = q_width(FRAMES_PER_MF, Q_STRIDE),
  localparam int POS_W         = $clog2(FRAMES_PER_MF)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frm_stb,
  input  logic                     rx_fa,
  input  logic                     rx_n,
  input  logic                     rx_m,
  input  logic                     rx_s,
  input  logic                     mf_en,
  input  logic [QW-1:0]            q_data,
  output logic                     tx_fa,
  output logic                     mf_sync,
  output logic [FRAMES_PER_MF-1:0] s_data,
  output logic                     irq_mf,
  output logic                     irq_sc
);
  logic [POS_W-1:0] pos_now;
  logic pos_zero, q_slot, pat_err, realign, at_start, mf_last, phased;
  logic hunting, locked, lock_nxt, commit;

  mfs_phase #(.FRAMES(FRAMES_PER_MF), .STRIDE(Q_STRIDE)) u_phase (
    .clk(clk), .rst(rst), .en(mf_en), .stb(frm_stb), .hunting(hunting),
    .rx_fa(rx_fa), .rx_n(rx_n), .rx_m(rx_m),
    .pos_now(pos_now), .pos_zero(pos_zero), .q_slot(q_slot),
    .pat_err(pat_err), .realign(realign), .at_start(at_start),
    .mf_last(mf_last), .phased(phased)
  );

  mfs_sync_fsm #(.ACQ_MF(ACQ_MF), .LOSS_MF(LOSS_MF)) u_fsm (
    .clk(clk), .rst(rst), .en(mf_en), .stb(frm_stb),
    .pat_err(pat_err), .realign(realign), .at_start(at_start),
    .mf_last(mf_last), .hunting(hunting), .locked(locked),
    .lock_nxt(lock_nxt)
  );

  mfs_qtx #(.QW(QW)) u_qtx (
    .clk(clk), .rst(rst), .en(mf_en), .locked(locked), .stb(frm_stb),
    .pos_zero(pos_zero), .q_slot(q_slot), .rx_fa(rx_fa), .q_in(q_data),
    .tx_fa(tx_fa)
  );

  assign commit = frm_stb && mf_last && lock_nxt;

  mfs_schan #(.FRAMES(FRAMES_PER_MF)) u_schan (
    .clk(clk), .rst(rst), .stb(frm_stb), .commit(commit),
    .pos_now(pos_now), .rx_s(rx_s), .s_data(s_data),
    .irq_mf(irq_mf), .irq_sc(irq_sc)
  );

  assign mf_sync = locked;

  // R10
  resync_needs_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mf_sync |-> phased);

  // R8
  irq_only_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mf |-> mf_sync);
endmodule

// File: tb/test_mfsync_term.sv
module test_mfsync_term;
  localparam int FR  = 20;
  localparam int STR = 5;
  localparam int QW  = 4;
  localparam int NV  = 8;
  // bit1: inject FA error in frame 8, bit0: expected mf_sync afterwards
  localparam logic [1:0] VEC [NV] = '{2'b00, 2'b01, 2'b11, 2'b01,
                                      2'b11, 2'b10, 2'b00, 2'b01};
  localparam logic [FR-1:0] FA_PAT = 20'h08421;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_stb = 1'b0, rx_fa = 1'b0, rx_n = 1'b0, rx_m = 1'b0, rx_s = 1'b0;
  logic mf_en = 1'b0;
  logic [QW-1:0] q_data = '0;
  logic tx_fa, mf_sync, irq_mf, irq_sc;
  logic [FR-1:0] s_data;

  int n_run = 0;
  int n_fail = 0;
  logic last_tx, last_mf, last_sc;
  logic [FR-1:0] tx_log, mid_s;
  int mf_irqs;
  logic sc_seen;

  always #5 clk = ~clk;

  mfsync_term i_mfsync_term (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .rx_fa(rx_fa), .rx_n(rx_n),
    .rx_m(rx_m), .rx_s(rx_s), .mf_en(mf_en), .q_data(q_data),
    .tx_fa(tx_fa), .mf_sync(mf_sync), .s_data(s_data),
    .irq_mf(irq_mf), .irq_sc(irq_sc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [FR-1:0] qpat(input logic [QW-1:0] q);
    logic [FR-1:0] r;
    r = '0;
    r[0]  = q[3];
    r[5]  = q[2];
    r[10] = q[1];
    r[15] = q[0];
    return r;
  endfunction

  task automatic send_frame(input logic fa, input logic n, input logic m, input logic s);
    @(negedge clk);
    rx_fa = fa; rx_n = n; rx_m = m; rx_s = s; frm_stb = 1'b1;
    @(negedge clk);
    frm_stb = 1'b0;
    last_tx = tx_fa;
    last_mf = irq_mf;
    last_sc = irq_sc;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frames(input int count, input int bad_pos, input logic [FR-1:0] sb,
                             input logic qchg, input logic [QW-1:0] qv);
    mf_irqs = 0;
    sc_seen = 1'b0;
    for (int p = 0; p < count; p++) begin
      logic qs;
      qs = ((p % STR) == 0);
      if (qchg && p == 3) q_data = qv;
      if (p == 10) mid_s = s_data;
      send_frame(qs ^ (p == bad_pos), !qs, p == 0, sb[p]);
      tx_log[p] = last_tx;
      if (last_mf) mf_irqs++;
      if (last_sc) sc_seen = 1'b1;
    end
  endtask

  task automatic send_mf(input int bad_pos, input logic [FR-1:0] sb,
                         input logic qchg, input logic [QW-1:0] qv);
    send_frames(FR, bad_pos, sb, qchg, qv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mf_sync", mf_sync, 0);
    check("R1 tx_fa", tx_fa, 0);
    check("R1 s_data", s_data, 0);
    check("R1 irq_mf", irq_mf, 0);
    check("R1 irq_sc", irq_sc, 0);

    // disabled: every frame mirrored, M bits ignored
    for (int i = 0; i < 6; i++) begin
      logic b;
      b = (8'b0010_1101 >> i) & 8'd1;
      send_frame(b, !b, i == 2, 1'b0);
      check("R2 mirror while disabled", last_tx, b);
    end
    check("R10 disabled keeps unsync", mf_sync, 0);

    mf_en = 1'b1;
    begin
      logic prev;
      prev = 1'b0;
      for (int v = 0; v < NV; v++) begin
        logic bad;
        logic [FR-1:0] pat;
        bad = VEC[v][1];
        pat = FA_PAT ^ (bad ? 20'h00080 : 20'h0);
        send_mf(bad ? 7 : -1, '0, 1'b0, '0);
        check("R3 R4 sync after multiframe", mf_sync, VEC[v][0]);
        check("R8 irq_mf count", mf_irqs, VEC[v][0] ? 1 : 0);
        check("R2 R5 upstream FA bits", tx_log, prev ? '0 : pat);
        prev = VEC[v][0];
      end
    end

    q_data = 4'b1011;
    send_mf(-1, '0, 1'b0, '0);
    check("R5 Q bits placed", tx_log, qpat(4'b1011));

    q_data = 4'b0110;
    send_mf(-1, '0, 1'b1, 4'b1001);
    check("R6 mid write deferred", tx_log, qpat(4'b0110));
    send_mf(-1, '0, 1'b0, '0);
    check("R6 new codeword next", tx_log, qpat(4'b1001));

    send_mf(-1, 20'hA5A5C, 1'b0, '0);
    check("R7 s_data held mid", mid_s, 0);
    check("R7 s_data copied", s_data, 20'hA5A5C);
    check("R9 change irq", sc_seen, 1);
    check("R8 irq per mf", mf_irqs, 1);
    send_mf(-1, 20'hA5A5C, 1'b0, '0);
    check("R9 no change no irq", sc_seen, 0);
    check("R8 irq per mf again", mf_irqs, 1);
    send_mf(-1, 20'h5A5A3, 1'b0, '0);
    check("R7 s_data held mid 2", mid_s, 20'hA5A5C);
    check("R7 s_data second", s_data, 20'h5A5A3);
    check("R9 change irq 2", sc_seen, 1);

    @(negedge clk);
    mf_en = 1'b0;
    @(negedge clk);
    check("R10 unsync next clock", mf_sync, 0);
    send_mf(-1, 20'hFFFFF, 1'b0, '0);
    check("R2 mirror after disable", tx_log, FA_PAT);
    check("R10 no irq while disabled", mf_irqs, 0);
    check("R7 s_data frozen unaligned", s_data, 20'h5A5A3);
    mf_en = 1'b1;
    send_mf(-1, '0, 1'b0, '0);
    check("R10 one mf not enough", mf_sync, 0);
    send_mf(-1, '0, 1'b0, '0);
    check("R10 reacquired", mf_sync, 1);

    @(negedge clk);
    mf_en = 1'b0;
    @(negedge clk);
    mf_en = 1'b1;
    send_mf(-1, '0, 1'b0, '0);
    check("R11 first clean mf", mf_sync, 0);
    send_frames(7, -1, '0, 1'b0, '0);
    send_mf(-1, '0, 1'b0, '0);
    check("R11 stray M discards count", mf_sync, 0);
    send_mf(-1, '0, 1'b0, '0);
    check("R11 lock after realign", mf_sync, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule